// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block drives instruction fetch for a small RISC core whose program and data memories sit on separate buses. It divides the main oscillator into instruction cycles of four clocks and holds a 13-bit program counter, which goes straight to the program memory address port. While the instruction held in the instruction register executes, the next word (14 bits) is fetched, so a straight-line instruction completes every cycle.

The execute stage reports control transfers: a plain jump, a subroutine call or a return. Any of these, or an accepted interrupt, throws away the prefetched word. The cycle that follows is then a fetch-only bubble, in which the execute-valid flag is low. Return addresses live in a hardware-only, eight-deep circular stack. Calls and interrupts push onto it and every return flavour pops from it.

Top module: `fetch_seq`

## Requirements
- R1: An instruction cycle is four clocks. `phase` counts 0,1,2,3 and wraps. `pmAddr` and `instr` change only at the clock edge that ends phase 3.
- R2: While `rstN` is low, `pmAddr` is 0000h, `execValid` is 0 and `phase` is 0. The first cycle after reset is fetch-only and ends with `instr` holding the word at 0000h.
- R3: In a cycle with no accepted request, the cycle end loads `instr` with the word read at `pmAddr` and raises `execValid`. It also increments `pmAddr` by one, modulo 8192, so 1FFFh is followed by 0000h.
- R4: An accepted `jumpReq` loads `target` into the program counter. The next cycle is a bubble with `execValid` low that fetches `target`, and the cycle after that executes the word at `target`.
- R5: An accepted `callReq` pushes the address being prefetched (the address after the calling instruction) and then behaves as a jump to `target`.
- R6: An accepted `retReq` pops the most recent stack entry into the program counter and produces a bubble.
- R7: An accepted `intReq` pushes the address being prefetched, loads 0004h and produces a bubble.
- R8: A request is sampled at the end of phase 3. When several requests are high, `retReq` wins over `callReq`, `callReq` over `jumpReq` and `jumpReq` over `intReq`. The losing requests have no effect on the program counter or the stack.
- R9: Requests are ignored in a cycle where `execValid` is low. Every bubble is followed by a valid cycle.
- R10: The stack holds eight entries. A ninth push overwrites the oldest entry. After nine calls, eight returns give the last eight return addresses newest first, and a ninth return gives the ninth (newest) one again.
- R11: Reset clears every stack entry, so a return with nothing pushed since reset loads 0000h. No error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pmAddr | output | 13 | Program memory word address (program counter) |
| pmData | input | 14 | Program memory read data for `pmAddr` |
| jumpReq | input | 1 | Executing instruction is a jump |
| callReq | input | 1 | Executing instruction is a call |
| retReq | input | 1 | Executing instruction is any return |
| target | input | 13 | Jump or call destination |
| intReq | input | 1 | Interrupt request, level sensitive |
| instr | output | 14 | Instruction register |
| execValid | output | 1 | `instr` is to be executed this cycle |
| phase | output | 2 | Clock phase within the instruction cycle |

## Verification
Runs of plain sequential cycles show the one-word-per-cycle increment and the wrap from 1FFFh to 0000h. A sweep of 64 jump targets spread over the whole 8K space separates a correct load from a stuck or truncated address bit, and also probes the bubble cycle with requests that must be ignored. Nested calls, a nine-deep call chain and an interrupt with its return show whether the pushed address is the prefetch address and whether the oldest entry is the one overwritten. Cycles with all requests raised at once separate the priority order, and a later return exposes any push made by a request that should have lost.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // strobes from control to the program counter datapath
  typedef struct packed {
    logic advance;    // last clock of the instruction cycle
    logic selTarget;  // load target (jump or call)
    logic selVector;  // load interrupt vector
    logic selPop;     // load top of return stack
  } pcCtl_t;

  // strobes from control to the return stack
  typedef struct packed {
    logic push;
    logic pop;
  } stkCtl_t;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic jumpReq,
  input  logic callReq,
  input  logic retReq,
  input  logic intReq,
  output pcCtl_t pcCtl,
  output stkCtl_t stkCtl,
  output logic execValid,
  output logic [$clog2(PHASES)-1:0] phase
);
  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic cycleEnd, accept;
  logic takeRet, takeCall, takeJump, takeInt, anyTake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (phase == LAST_PH) phase <= '0;
    else phase <= phase + PH_W'(1);
  end

  assign cycleEnd = (phase == LAST_PH);
  assign accept   = cycleEnd && execValid;

  // fixed priority: return, call, jump, interrupt (R8)
  assign takeRet  = accept && retReq;
  assign takeCall = accept && !retReq && callReq;
  assign takeJump = accept && !retReq && !callReq && jumpReq;
  assign takeInt  = accept && !retReq && !callReq && !jumpReq && intReq;
  assign anyTake  = takeRet || takeCall || takeJump || takeInt;

  always_comb begin
    pcCtl.advance   = cycleEnd;
    pcCtl.selTarget = takeCall || takeJump;
    pcCtl.selVector = takeInt;
    pcCtl.selPop    = takeRet;
    stkCtl.push     = takeCall || takeInt;
    stkCtl.pop      = takeRet;
  end

  // any control transfer flushes the prefetched word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) execValid <= 1'b0;
    else if (cycleEnd) execValid <= !anyTake;
  end

  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (phase == LAST_PH) |=> (phase == '0));
  a_r1_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    (phase != LAST_PH) |=> (phase == PH_W'($past(phase) + PH_W'(1))));
  a_r9_single_bubble: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEnd && !execValid) |=> execValid);
  a_r8_one_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pcCtl.selTarget, pcCtl.selVector, pcCtl.selPop}));

endmodule

// File: rtl/fetch_dpath.sv
module fetch_dpath
  import fetch_pkg::*;
#(
  parameter int PC_W = 13,
  parameter int IW = 14,
  parameter logic [PC_W-1:0] INT_VECTOR = 13'h0004
) (
  input  logic clk,
  input  logic rstN,
  input  pcCtl_t pcCtl,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] popData,
  input  logic [IW-1:0] pmData,
  output logic [PC_W-1:0] pc,
  output logic [IW-1:0] instr
);
  logic [PC_W-1:0] pcNext;

  always_comb begin
    if (pcCtl.selPop) pcNext = popData;
    else if (pcCtl.selTarget) pcNext = target;
    else if (pcCtl.selVector) pcNext = INT_VECTOR;
    else pcNext = pc + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc    <= '0;
      instr <= '0;
    end else if (pcCtl.advance) begin
      pc    <= pcNext;
      instr <= pmData;
    end
  end

  a_r1_hold_midcycle: assert property (@(posedge clk) disable iff (!rstN)
    !pcCtl.advance |=> ($stable(pc) && $stable(instr)));
  a_r7_vector_load: assert property (@(posedge clk) disable iff (!rstN)
    (pcCtl.advance && pcCtl.selVector) |=> (pc == INT_VECTOR));
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    (pcCtl.advance && !pcCtl.selPop && !pcCtl.selTarget && !pcCtl.selVector)
      |=> (pc == PC_W'($past(pc) + PC_W'(1))));

endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import fetch_pkg::*;
#(
  parameter int W = 13,
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rstN,
  input  stkCtl_t stkCtl,
  input  logic [W-1:0] pushData,
  output logic [W-1:0] popData
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0] entry [DEPTH];
  logic [PTR_W-1:0] sp;
  logic [DEPTH-1:0] wrSel;

  // circular: pointer wraps, oldest slot is overwritten (R10)
  for (genvar g = 0; g < DEPTH; g++) begin : g_wrsel
    assign wrSel[g] = stkCtl.push && (sp == PTR_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) entry[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++)
        if (wrSel[k]) entry[k] <= pushData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sp <= '0;
    else if (stkCtl.push) sp <= sp + PTR_W'(1);
    else if (stkCtl.pop) sp <= sp - PTR_W'(1);
  end

  assign popData = entry[sp - PTR_W'(1)];

  a_r10_push_ptr: assert property (@(posedge clk) disable iff (!rstN)
    stkCtl.push |=> (sp == PTR_W'($past(sp) + PTR_W'(1))));
  a_r6_pop_ptr: assert property (@(posedge clk) disable iff (!rstN)
    (stkCtl.pop && !stkCtl.push) |=> (sp == PTR_W'($past(sp) - PTR_W'(1))));
  a_r5_push_lands: assert property (@(posedge clk) disable iff (!rstN)
    stkCtl.push |=> (popData == $past(pushData)));

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int PC_W = 13,
  parameter int IW = 14,
  parameter int STACK_DEPTH = 8,
  parameter int PHASES = 4,
  parameter logic [PC_W-1:0] INT_VECTOR = 13'h0004
) (
  input  logic clk,
  input  logic rstN,
  output logic [PC_W-1:0] pmAddr,
  input  logic [IW-1:0] pmData,
  input  logic jumpReq,
  input  logic callReq,
  input  logic retReq,
  input  logic [PC_W-1:0] target,
  input  logic intReq,
  output logic [IW-1:0] instr,
  output logic execValid,
  output logic [$clog2(PHASES)-1:0] phase
);
  pcCtl_t pcCtl;
  stkCtl_t stkCtl;
  logic [PC_W-1:0] pc, popData;

  fetch_ctrl #(.PHASES(PHASES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .jumpReq(jumpReq), .callReq(callReq), .retReq(retReq), .intReq(intReq),
    .pcCtl(pcCtl), .stkCtl(stkCtl), .execValid(execValid), .phase(phase)
  );

  fetch_dpath #(.PC_W(PC_W), .IW(IW), .INT_VECTOR(INT_VECTOR)) u_dpath (
    .clk(clk), .rstN(rstN), .pcCtl(pcCtl), .target(target),
    .popData(popData), .pmData(pmData), .pc(pc), .instr(instr)
  );

  ret_stack #(.W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rstN(rstN), .stkCtl(stkCtl),
    .pushData(pc), .popData(popData)
  );

  assign pmAddr = pc;

endmodule

// File: tb/test_fetch_seq.sv
module test_fetch_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [12:0] pmAddr, target;
  logic [13:0] pmData, instr;
  logic jumpReq, callReq, retReq, intReq, execValid;
  logic [1:0] phase;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  logic [12:0] expPc;
  logic [13:0] expIr;
  logic expValid;
  logic [12:0] mStk [8];
  int mSp;

  always #2.5 clk = ~clk;

  function automatic logic [13:0] memWord(input logic [12:0] a);
    logic [13:0] w;
    w = 14'(a[9:0]) * 14'd37 + 14'd11;
    return w ^ 14'h2A55;
  endfunction

  assign pmData = memWord(pmAddr);

  fetch_seq i_fetch_seq (
    .clk(clk), .rstN(rstN), .pmAddr(pmAddr), .pmData(pmData),
    .jumpReq(jumpReq), .callReq(callReq), .retReq(retReq), .target(target),
    .intReq(intReq), .instr(instr), .execValid(execValid), .phase(phase)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one instruction cycle with the given requests, then compare with the model
  task automatic step(input logic j, input logic c, input logic r, input logic i,
                      input logic [12:0] t, input string tag);
    logic [12:0] oldPc, newPc;
    logic nv;
    jumpReq = j; callReq = c; retReq = r; intReq = i; target = t;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "mid-cycle phase", 32'(phase), 32'd2);
    chk("R1", "mid-cycle pmAddr", 32'(pmAddr), 32'(expPc));
    repeat (2) @(posedge clk);
    @(negedge clk);
    oldPc = expPc;
    nv = 1'b0;
    if (expValid && r) begin
      mSp = (mSp + 7) % 8; newPc = mStk[mSp];
    end else if (expValid && c) begin
      mStk[mSp] = oldPc; mSp = (mSp + 1) % 8; newPc = t;
    end else if (expValid && j) begin
      newPc = t;
    end else if (expValid && i) begin
      mStk[mSp] = oldPc; mSp = (mSp + 1) % 8; newPc = 13'h0004;
    end else begin
      newPc = oldPc + 13'd1; nv = 1'b1;
    end
    expIr = memWord(oldPc);
    expPc = newPc;
    expValid = nv;
    chk(tag, "pmAddr", 32'(pmAddr), 32'(expPc));
    chk(tag, "instr", 32'(instr), 32'(expIr));
    chk(tag, "execValid", 32'(execValid), 32'(expValid));
    chk("R1", "phase at cycle start", 32'(phase), 32'd0);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 13'h0, tag);
  endtask

  initial begin
    jumpReq = 0; callReq = 0; retReq = 0; intReq = 0; target = '0;
    expPc = '0; expIr = '0; expValid = 1'b0; mSp = 0;
    for (int k = 0; k < 8; k++) mStk[k] = '0;

    // R2: reset state
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R2", "reset pmAddr", 32'(pmAddr), 32'd0);
    chk("R2", "reset execValid", 32'(execValid), 32'd0);
    chk("R2", "reset phase", 32'(phase), 32'd0);
    rstN = 1'b1;

    // R9: the fetch-only cycle after reset ignores a jump; R2 first word
    step(1'b1, 1'b0, 1'b0, 1'b0, 13'h0100, "R9");
    chk("R2", "first word", 32'(instr), 32'(memWord(13'h0000)));
    for (int k = 0; k < 5; k++) idle("R3");

    // R11: return on empty stack loads 0000h
    step(1'b0, 1'b0, 1'b1, 1'b0, 13'h0, "R11");
    chk("R11", "empty pop address", 32'(pmAddr), 32'd0);
    idle("R11");
    idle("R3");

    // R4 / R9: jump target sweep over the whole address space
    for (int k = 0; k < 64; k++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, 13'((k * 131 + 7) % 8192), "R4");
      if (k % 4 == 1) step(1'b0, 1'b1, 1'b1, 1'b1, 13'h0ABC, "R9");
      else idle("R4");
      idle("R4");
    end

    // R5 / R6: nested calls and returns
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0, 13'(13'h0200 + k * 32), "R5");
      idle("R5");
      idle("R5");
    end
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b0, 1'b1, 1'b0, 13'h0, "R6");
      idle("R6");
    end

    // R10: nine-deep call chain overwrites the oldest entry
    for (int k = 0; k < 9; k++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0, 13'(13'h0300 + k * 16), "R10");
      idle("R10");
    end
    for (int k = 0; k < 9; k++) begin
      step(1'b0, 1'b0, 1'b1, 1'b0, 13'h0, "R10");
      idle("R10");
    end

    // R7: interrupt then return
    idle("R3");
    step(1'b0, 1'b0, 1'b0, 1'b1, 13'h0, "R7");
    chk("R7", "vector", 32'(pmAddr), 32'h4);
    idle("R7");
    idle("R7");
    step(1'b0, 1'b0, 1'b1, 1'b0, 13'h0, "R7");
    idle("R7");

    // R8: priority among simultaneous requests
    step(1'b0, 1'b1, 1'b0, 1'b0, 13'h0123, "R8");
    idle("R8");
    idle("R8");
    step(1'b1, 1'b1, 1'b1, 1'b1, 13'h0777, "R8");
    idle("R8");
    step(1'b1, 1'b1, 1'b0, 1'b1, 13'h0456, "R8");
    idle("R8");
    step(1'b1, 1'b0, 1'b0, 1'b1, 13'h0BCD, "R8");
    idle("R8");
    step(1'b0, 1'b0, 1'b1, 1'b0, 13'h0, "R8");
    idle("R8");

    // R3: wrap from 1FFFh to 0000h
    step(1'b1, 1'b0, 1'b0, 1'b0, 13'h1FFE, "R3");
    idle("R3");
    idle("R3");
    idle("R3");
    chk("R3", "wrap address", 32'(pmAddr), 32'h0001);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule